// File: doc/BRIEF.md
# Strided Vector Address Generator

This block produces the sequence of memory addresses for one vector load or store. A single start pulse captures a base address, a signed stride and an element count. The block then presents one element address per accepted handshake, stepping by the stride each time. The address arithmetic wraps at the address width. Unit stride walks a row of a row-major square matrix. A stride equal to the matrix order walks a column. The order plus one walks the main diagonal.

A vector register holds only a fixed number of elements, so a long vector is issued as a series of segments. Each segment is at most one register long, and the final segment may be shorter. Alongside every address the block gives the destination slot inside the register. That slot restarts at zero with each segment. The block also flags the last element of each segment and the last element of the whole vector. It produces a one-cycle completion pulse once the access has finished. Toward memory it uses only a valid/ready handshake.

Top module: `strided_addr_gen`

## Requirements
- R1: After reset, `addrValid`, `busy` and `done` are low.
- R2: When `start` is high while `busy` is low and `vecLen` is nonzero, the block becomes busy on the next cycle. It then presents `addrValid` high with `addr` equal to `baseAddr` and `slot` equal to 0.
- R3: Element k is presented with `addr` = `baseAddr` + k·`stride` modulo 2^ADDR_W. `stride` is read as two's complement, so a negative stride walks downward and can wrap through zero.
- R4: The presented element changes only on a cycle where both `addrValid` and `addrReady` are high. While `addrReady` is low, `addr`, `slot` and the flags hold their values.
- R5: `slot` counts 0, 1, … up to REG_ELEMS−1. It returns to 0 for the first element of each new segment, so element k uses slot k mod REG_ELEMS.
- R6: `segLast` is high exactly on the elements whose slot is REG_ELEMS−1, and on the final element of the vector. This also covers a short final segment.
- R7: `vecLast` is high only on the final element. One cycle after that element is accepted, `done` pulses high for exactly one cycle, and `busy` and `addrValid` drop.
- R8: A start with `vecLen` = 0 issues no element. `addrValid` stays low, and `done` pulses for one cycle in the cycle after the start.
- R9: `start` is ignored while `busy` is high. The running sequence of addresses and slots is unaffected.
- R10: Exactly `vecLen` elements are accepted per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an access with the values on the three descriptor inputs |
| baseAddr | input | ADDR_W | Address of element 0 |
| stride | input | ADDR_W | Signed element-to-element address step |
| vecLen | input | LEN_W | Number of elements in the vector |
| busy | output | 1 | An access is in progress |
| addrValid | output | 1 | `addr` holds an element to be accepted |
| addrReady | input | 1 | Memory side accepts the presented element |
| addr | output | ADDR_W | Element address |
| slot | output | SLOT_W | Slot within the vector register for this element |
| segLast | output | 1 | Presented element closes a segment |
| vecLast | output | 1 | Presented element is the last of the vector |
| done | output | 1 | One-cycle pulse when the access has finished |

## Verification
The bench targets segment boundaries. It uses a vector that is an exact multiple of the register size, one with a short tail, and a one-element vector. A design that fails to clear the slot, or that misses `segLast` on a short tail, shows a wrong slot or flag at those elements. Back-pressure is applied in a repeating stall pattern. A design that advances without a handshake skips or repeats addresses. A negative stride that wraps through zero exposes unsigned or narrowed arithmetic. A zero-length start and a start issued mid-vector catch a design that issues a spurious element or restarts on an ignored request.

// File: rtl/agen_pkg.sv
package agen_pkg;
  // Strobes sent from the sequencing control to the address datapath.
  typedef struct packed {
    logic load;     // capture base and stride
    logic advance;  // step to the next element address
  } agenStrobes_t;
endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import agen_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int REG_ELEMS = 8,
  parameter int SLOT_W    = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [LEN_W-1:0]   vecLen,
  input  logic               addrReady,
  output agenStrobes_t       strobes,
  output logic               busy,
  output logic [SLOT_W-1:0]  slot,
  output logic               segLast,
  output logic               vecLast,
  output logic               done
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(REG_ELEMS - 1);

  logic              busyQ;
  logic              doneQ;
  logic [LEN_W-1:0]  remainQ;
  logic [SLOT_W-1:0] slotQ;
  logic              accept;
  logic              finalElem;

  assign accept    = busyQ && addrReady;
  assign finalElem = (remainQ == LEN_W'(1));

  always_comb begin
    strobes.load    = start && !busyQ && (vecLen != '0);
    strobes.advance = accept && !finalElem;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      remainQ <= '0;
      slotQ   <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (start) begin
          if (vecLen == '0) begin
            doneQ <= 1'b1;
          end else begin
            busyQ   <= 1'b1;
            remainQ <= vecLen;
            slotQ   <= '0;
          end
        end
      end else if (accept) begin
        if (finalElem) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          remainQ <= remainQ - LEN_W'(1);
          slotQ   <= (slotQ == LAST_SLOT) ? '0 : slotQ + SLOT_W'(1);
        end
      end
    end
  end

  assign busy    = busyQ;
  assign slot    = slotQ;
  assign done    = doneQ;
  assign vecLast = busyQ && finalElem;
  assign segLast = busyQ && (finalElem || (slotQ == LAST_SLOT));
endmodule

// File: rtl/agen_datapath.sv
module agen_datapath
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  agenStrobes_t      strobes,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] stride,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] strideQ;

  // Two's-complement addition wraps naturally at ADDR_W bits.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      strideQ <= '0;
    end else if (strobes.load) begin
      addrQ   <= baseAddr;
      strideQ <= stride;
    end else if (strobes.advance) begin
      addrQ <= addrQ + strideQ;
    end
  end

  assign addr = addrQ;
endmodule

// File: rtl/strided_addr_gen.sv
module strided_addr_gen
  import agen_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int REG_ELEMS = 8,
  localparam int SLOT_W   = (REG_ELEMS > 1) ? $clog2(REG_ELEMS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  vecLen,
  output logic              busy,
  output logic              addrValid,
  input  logic              addrReady,
  output logic [ADDR_W-1:0] addr,
  output logic [SLOT_W-1:0] slot,
  output logic              segLast,
  output logic              vecLast,
  output logic              done
);
  agenStrobes_t strobes;

  agen_ctrl #(.LEN_W(LEN_W), .REG_ELEMS(REG_ELEMS), .SLOT_W(SLOT_W)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen),
    .addrReady(addrReady), .strobes(strobes), .busy(busy), .slot(slot),
    .segLast(segLast), .vecLast(vecLast), .done(done)
  );

  agen_datapath #(.ADDR_W(ADDR_W)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .baseAddr(baseAddr),
    .stride(stride), .addr(addr)
  );

  assign addrValid = busy;
endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
  parameter int ADDR_W    = 32,
  parameter int REG_ELEMS = 8,
  parameter int SLOT_W    = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic [ADDR_W-1:0] stride,
  input logic              addrValid,
  input logic              addrReady,
  input logic [ADDR_W-1:0] addr,
  input logic [SLOT_W-1:0] slot,
  input logic              segLast,
  input logic              vecLast,
  input logic              done
);
  logic [ADDR_W-1:0] strideSeen;
  logic              fire;

  assign fire = addrValid && addrReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strideSeen <= '0;
    else if (start && !busy) strideSeen <= stride;
  end

  AST_STEP_BY_STRIDE: assert property (@(posedge clk) disable iff (!rstN)
    fire && !vecLast |=> addrValid && (addr == $past(addr) + strideSeen)); // R3

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !addrReady |=> addrValid && $stable(addr) && $stable(slot)); // R4

  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (int'(slot) < REG_ELEMS)); // R5

  AST_SEGMENT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    fire && segLast && !vecLast |=> slot == '0); // R5

  AST_LAST_CLOSES_SEG: assert property (@(posedge clk) disable iff (!rstN)
    vecLast |-> segLast && addrValid); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    fire && vecLast |=> done && !addrValid); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
endmodule

bind strided_addr_gen agen_checker #(
  .ADDR_W(ADDR_W), .REG_ELEMS(REG_ELEMS), .SLOT_W(SLOT_W)
) agenChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .stride(stride),
  .addrValid(addrValid), .addrReady(addrReady), .addr(addr), .slot(slot),
  .segLast(segLast), .vecLast(vecLast), .done(done)
);

// File: tb/strided_addr_gen_test.sv
`timescale 1ns/1ps
module strided_addr_gen_test;
  localparam int ADDR_W = 32;
  localparam int LEN_W = 16;
  localparam int REG_ELEMS = 8;
  localparam int SLOT_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [ADDR_W-1:0] stride = '0;
  logic [LEN_W-1:0] vecLen = '0;
  logic addrReady = 1'b0;
  logic busy, addrValid, segLast, vecLast, done;
  logic [ADDR_W-1:0] addr;
  logic [SLOT_W-1:0] slot;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  strided_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_ELEMS(REG_ELEMS)) uut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .stride(stride),
    .vecLen(vecLen), .busy(busy), .addrValid(addrValid), .addrReady(addrReady),
    .addr(addr), .slot(slot), .segLast(segLast), .vecLast(vecLast), .done(done)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  // Runs one access; stallMode inserts a not-ready cycle every third cycle,
  // poke issues a stray start during the first element.
  task automatic runVec(input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] s,
                        input int len, input bit stallMode, input bit poke);
    int k = 0;
    int cyc = 0;
    int accepted = 0;
    logic [ADDR_W-1:0] expAddr;
    @(negedge clk);
    baseAddr = b; stride = s; vecLen = LEN_W'(len); start = 1'b1; addrReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", 64'(busy), 64'(1));
    while (k < len) begin
      expAddr = b + ADDR_W'(k) * s;
      check("R3/R4 addr", 64'(addr), 64'(expAddr));
      check("R2/R4 valid", 64'(addrValid), 64'(1));
      check("R5 slot", 64'(slot), 64'(k % REG_ELEMS));
      check("R6 segLast", 64'(segLast), 64'(((k % REG_ELEMS) == REG_ELEMS - 1) || (k == len - 1)));
      check("R7 vecLast", 64'(vecLast), 64'(k == len - 1));
      if (poke && k == 0 && cyc == 0) begin
        // R9: stray start with a different descriptor must be ignored
        start = 1'b1; baseAddr = b ^ 32'h5555_0000; stride = s + 32'd7; vecLen = LEN_W'(3);
      end else begin
        start = 1'b0;
      end
      addrReady = stallMode ? ((cyc % 3) != 0) : 1'b1;
      @(negedge clk);
      if (addrReady) begin
        k++;
        accepted++;
      end
      cyc++;
    end
    start = 1'b0;
    addrReady = 1'b0;
    check("R7 done pulse", 64'(done), 64'(1));
    check("R7 valid drops", 64'(addrValid), 64'(0));
    check("R7 busy drops", 64'(busy), 64'(0));
    check("R10 element count", 64'(accepted), 64'(len));
    @(negedge clk);
    check("R7 done one cycle", 64'(done), 64'(0));
  endtask

  task automatic testReset();
    check("R1 valid at reset", 64'(addrValid), 64'(0));
    check("R1 busy at reset", 64'(busy), 64'(0));
    check("R1 done at reset", 64'(done), 64'(0));
  endtask

  task automatic testZeroLength();
    @(negedge clk);
    baseAddr = 32'h100; stride = 32'd4; vecLen = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 done after empty start", 64'(done), 64'(1));
    check("R8 no valid", 64'(addrValid), 64'(0));
    @(negedge clk);
    check("R8 done ends", 64'(done), 64'(0));
    check("R8 still no valid", 64'(addrValid), 64'(0));
  endtask

  task automatic testStallHold();
    logic [ADDR_W-1:0] held;
    @(negedge clk);
    baseAddr = 32'h2000; stride = 32'd16; vecLen = LEN_W'(2); start = 1'b1; addrReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    held = addr;
    repeat (3) @(negedge clk);
    check("R4 addr held while not ready", 64'(addr), 64'(held));
    check("R4 slot held while not ready", 64'(slot), 64'(0));
    addrReady = 1'b1;
    @(negedge clk);
    check("R4 advanced after handshake", 64'(addr), 64'(32'h2010));
    @(negedge clk);
    addrReady = 1'b0;
    check("R7 done after short vector", 64'(done), 64'(1));
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #1;
    testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    runVec(32'h1000, 32'd1, 5, 1'b0, 1'b0);          // row, short single segment
    runVec(32'h4000, 32'd4, 20, 1'b1, 1'b0);         // column, 8+8+4 with stalls
    runVec(32'h8000, 32'd5, 16, 1'b0, 1'b0);         // diagonal, exact two segments
    runVec(32'd2, 32'hFFFF_FFFD, 3, 1'b0, 1'b0);     // negative stride wraps through zero
    runVec(32'h3000, 32'd8, 10, 1'b1, 1'b1);         // stray start ignored (R9)
    runVec(32'hFFFF_FFF0, 32'd8, 1, 1'b0, 1'b0);     // single element
    testZeroLength();
    testStallHold();
    summary();
  end
endmodule